// File: doc/BRIEF.md
# In-line ECC Write Parity Packer

This block is the write datapath for a memory controller that keeps its error-correction codes in ordinary memory space rather than on extra data lines. Every write word is 512 bits, seen as eight 64-bit bursts. Eight encoders compute one check byte per burst, so a word yields 64 check bits. The user data is passed to the output unchanged. The 64 check bits of the word are filed into one of eight 64-bit slots of a 512-bit parity accumulator. A request flagged as overhead carries no user data. It emits the accumulated parity word so that the parity of up to eight consecutive writes lands in memory with a single extra write.

The request stream is ordered and uses valid/ready flow control. A two-register pipeline is driven by a three-state controller. The output register holds the word being offered downstream. A one-entry skid register catches a request that arrives while the output is stalled. The states are: `ST_IDLE` (nothing held), `ST_HOLD` (output register full, skid empty) and `ST_FULL` (both full, input not ready). The transitions are:
- `ST_IDLE` goes to `ST_HOLD` on an accepted request.
- `ST_HOLD` goes to `ST_FULL` when a request arrives during a stall.
- `ST_HOLD` goes to `ST_IDLE` when the output drains and no request arrives.
- `ST_HOLD` stays in `ST_HOLD` when the output drains and a new request arrives in the same cycle.
- `ST_FULL` goes to `ST_HOLD` when the output drains; the skid word then moves into the output register.

Encoding and accumulator update take place when a request is loaded into the output register. This happens in request order.

Top module: `inline_ecc_wr_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, and the accumulator is all zero: an overhead request issued first produces a zero word.
- R2: A normal request (`in_ovh`=0) appears at the output with `out_data` equal to `in_data` and `out_ovh`=0.
- R3: Each 64-bit burst b gets a check byte {P, H[6:0]}. Data bit k takes the k-th code position in 1..71 that is not a power of two. H[i] is the XOR of the data bits whose position has bit i set. P is the XOR of all data bits and all H bits. For example, a burst equal to 1 gives 0x83.
- R4: An overhead request outputs the accumulator with `out_ovh`=1. Burst b of slot s occupies `out_data[64*s+8*b +: 8]`. The `in_data` of an overhead request is ignored.
- R5: The accumulator is cleared once an overhead request loads. A slot not written since then reads zero in the next overhead word.
- R6: A later normal request to the same slot replaces the earlier check bits in that slot.
- R7: `in_ready` drops only when one word waits at the output and a second sits in the skid register. No request is lost, duplicated or reordered under any pattern of `out_ready`.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_ovh` hold their values.
- R9: Parity of a normal request accepted before an overhead request is included in that overhead word, even if the normal request was still stalled when the overhead request arrived.
- R10: The slot is `in_col[5:3]`; the other column bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_ovh | input | 1 | 1 = overhead (parity) write, 0 = user write |
| in_col | input | 10 | Column address of the request; bits [5:3] choose the slot |
| in_data | input | 512 | User write word, eight 64-bit bursts |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_ovh | output | 1 | Output word is a parity word |
| out_data | output | 512 | User data or packed parity word |

## Verification
The hardest case to reach is the one R9 describes: an overhead request arriving while the normal writes it must cover are still stalled in the output and skid registers. The bench holds `out_ready` low and pushes two writes to fill both registers. It checks that `in_ready` has dropped, then offers an overhead request that must wait, and releases the stall. A long phase with random `out_ready` and overhead requests every few writes then crosses every state transition against a queued model of the expected words.

// File: rtl/iecc_pkg.sv
package iecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_FULL
    } stage_st_e;

    // Number of Hamming bits needed to cover a data width.
    function automatic int unsigned ham_bits(int unsigned data_w);
        int unsigned r;
        r = 1;
        for (int unsigned t = 1; t < 16; t++) begin
            if ((1 << r) < (data_w + r + 1)) r = r + 1;
        end
        return r;
    endfunction

    // Code position (1-based) of data bit idx, skipping powers of two.
    function automatic int unsigned data_pos(int unsigned idx);
        int unsigned n;
        int unsigned res;
        n   = 0;
        res = 0;
        for (int unsigned q = 1; q < 1024; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == idx && res == 0) res = q;
                n = n + 1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/iecc_secded_enc.sv
module iecc_secded_enc
    import iecc_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned HAM_W = ham_bits(DATA_W),
    localparam int unsigned CHK_W = HAM_W + 1
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  check
);

    logic [HAM_W-1:0] ham;

    always_comb begin
        ham = '0;
        for (int unsigned k = 0; k < DATA_W; k++) begin
            for (int unsigned b = 0; b < HAM_W; b++) begin
                if (((data_pos(k) >> b) & 1) == 1) ham[b] = ham[b] ^ data[k];
            end
        end
    end

    assign check = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/iecc_parity_acc.sv
module iecc_parity_acc #(
    parameter int unsigned SLOT_W_BITS = 64,
    parameter int unsigned NUM_SLOTS   = 8,
    localparam int unsigned IDX_W  = $clog2(NUM_SLOTS),
    localparam int unsigned WORD_W = SLOT_W_BITS * NUM_SLOTS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_norm,
    input  logic                   load_ovh,
    input  logic [IDX_W-1:0]       slot,
    input  logic [SLOT_W_BITS-1:0] slot_bits,
    output logic [WORD_W-1:0]      acc_word
);

    logic [SLOT_W_BITS-1:0] slot_q [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (load_ovh) begin
                slot_q[s] <= '0;
            end else if (load_norm && slot == IDX_W'(s)) begin
                slot_q[s] <= slot_bits;
            end
        end
        assign acc_word[s*SLOT_W_BITS +: SLOT_W_BITS] = slot_q[s];
    end

    AST_CLEAR_AFTER_OVH: assert property (@(posedge clk) disable iff (!rst_n)
        load_ovh |=> (acc_word == '0)); // R5

    AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_norm && load_ovh)); // R4

endmodule

// File: rtl/iecc_stage_ctl.sv
module iecc_stage_ctl
    import iecc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load_out,
    output logic sel_skid,
    output logic load_skid
);

    stage_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d      = st_q;
        in_ready  = 1'b1;
        out_valid = 1'b0;
        load_out  = 1'b0;
        sel_skid  = 1'b0;
        load_skid = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (in_valid) begin
                    load_out = 1'b1;
                    st_d     = ST_HOLD;
                end
            end
            ST_HOLD: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    if (in_valid) load_out = 1'b1;
                    else          st_d = ST_IDLE;
                end else if (in_valid) begin
                    load_skid = 1'b1;
                    st_d      = ST_FULL;
                end
            end
            ST_FULL: begin
                out_valid = 1'b1;
                in_ready  = 1'b0;
                if (out_ready) begin
                    load_out = 1'b1;
                    sel_skid = 1'b1;
                    st_d     = ST_HOLD;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    AST_VALID_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid); // R7

    AST_READY_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> in_ready); // R7

    AST_SKID_NEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid); // R7

endmodule

// File: rtl/inline_ecc_wr_packer.sv
module inline_ecc_wr_packer
    import iecc_pkg::*;
#(
    parameter int unsigned BURST_W   = 64,
    parameter int unsigned NUM_BURST = 8,
    parameter int unsigned COL_W     = 10,
    parameter int unsigned SLOT_LSB  = 3,
    localparam int unsigned WORD_W   = BURST_W * NUM_BURST,
    localparam int unsigned CHK_W    = ham_bits(BURST_W) + 1,
    localparam int unsigned GRP_W    = CHK_W * NUM_BURST,
    localparam int unsigned NUM_SLOT = WORD_W / GRP_W,
    localparam int unsigned IDX_W    = $clog2(NUM_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_ovh,
    input  logic [COL_W-1:0]  in_col,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_ovh,
    output logic [WORD_W-1:0] out_data
);

    logic load_out, sel_skid, load_skid;

    logic              skid_ovh_q;
    logic [COL_W-1:0]  skid_col_q;
    logic [WORD_W-1:0] skid_data_q;

    logic              src_ovh;
    logic [COL_W-1:0]  src_col;
    logic [WORD_W-1:0] src_data;
    logic [GRP_W-1:0]  src_chk;
    logic [WORD_W-1:0] acc_word;

    iecc_stage_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load_out  (load_out),
        .sel_skid  (sel_skid),
        .load_skid (load_skid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skid_ovh_q  <= 1'b0;
            skid_col_q  <= '0;
            skid_data_q <= '0;
        end else if (load_skid) begin
            skid_ovh_q  <= in_ovh;
            skid_col_q  <= in_col;
            skid_data_q <= in_data;
        end
    end

    assign src_ovh  = sel_skid ? skid_ovh_q  : in_ovh;
    assign src_col  = sel_skid ? skid_col_q  : in_col;
    assign src_data = sel_skid ? skid_data_q : in_data;

    for (genvar b = 0; b < NUM_BURST; b++) begin : g_enc
        iecc_secded_enc #(.DATA_W(BURST_W)) u_enc (
            .data  (src_data[b*BURST_W +: BURST_W]),
            .check (src_chk[b*CHK_W +: CHK_W])
        );
    end

    iecc_parity_acc #(.SLOT_W_BITS(GRP_W), .NUM_SLOTS(NUM_SLOT)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_norm (load_out && !src_ovh),
        .load_ovh  (load_out && src_ovh),
        .slot      (src_col[SLOT_LSB +: IDX_W]),
        .slot_bits (src_chk),
        .acc_word  (acc_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_ovh  <= 1'b0;
            out_data <= '0;
        end else if (load_out) begin
            out_ovh  <= src_ovh;
            out_data <= src_ovh ? acc_word : src_data;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_ovh))); // R8

    AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !out_ready) |=> ($stable(skid_data_q) && !in_ready)); // R7

endmodule

// File: tb/inline_ecc_wr_packer_test.sv
`timescale 1ns/1ps
module inline_ecc_wr_packer_test;

    typedef struct {
        logic [511:0] d;
        logic         ovh;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_ovh = 1'b0;
    logic [9:0]   in_col = '0;
    logic [511:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic         out_ovh;
    logic [511:0] out_data;

    int checks = 0;
    int fails  = 0;
    int ready_mode = 0;   // 0 always, 1 never, 2 random
    exp_t exp_q[$];
    logic [511:0] model_acc = '0;
    string cur_tag = "R2";

    always #2.5 clk = ~clk;

    inline_ecc_wr_packer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ovh(in_ovh), .in_col(in_col), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_ovh(out_ovh), .out_data(out_data)
    );

    function automatic logic [7:0] chk_byte(logic [63:0] d);
        logic [6:0] h;
        int idx;
        h = '0;
        idx = 0;
        for (int pos = 1; pos <= 71; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (d[idx]) h = h ^ 7'(pos);
                idx++;
            end
        end
        return {(^d) ^ (^h), h};
    endfunction

    function automatic logic [511:0] rand_word();
        logic [511:0] w;
        for (int i = 0; i < 16; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    task automatic check(string req, logic ok, logic [511:0] act, logic [511:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send(logic [511:0] d, logic [9:0] col, logic ovh);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_col = col; in_ovh = ovh;
        forever begin
            #1;
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        if (ovh) begin
            e.d = model_acc; e.ovh = 1'b1; model_acc = '0;
        end else begin
            e.d = d; e.ovh = 1'b0;
            for (int b = 0; b < 8; b++)
                model_acc[col[5:3]*64 + b*8 +: 8] = chk_byte(d[b*64 +: 64]);
        end
        e.tag = cur_tag;
        exp_q.push_back(e);
        #0.1;
        in_valid = 1'b0;
    endtask

    // ready driver
    always @(negedge clk) begin
        if (ready_mode == 0)      out_ready <= 1'b1;
        else if (ready_mode == 1) out_ready <= 1'b0;
        else                      out_ready <= ($urandom % 3) != 0;
    end

    // monitor / scoreboard
    logic         prev_stall = 1'b0;
    logic [511:0] prev_data;
    logic         prev_ovh;
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (prev_stall)
                check("R8", out_valid && out_data == prev_data && out_ovh == prev_ovh,
                      out_data, prev_data);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R7", 1'b0, out_data, '0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, out_data == e.d && out_ovh == e.ovh, out_data, e.d);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_ovh   = out_ovh;
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [511:0] w;
        logic [511:0] hand;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1", out_valid == 1'b0 && in_ready == 1'b1, {510'b0, out_valid, in_ready}, 512'b1);
        rst_n = 1'b1;

        // R1: accumulator zero after reset
        cur_tag = "R1";
        send(rand_word(), 10'd0, 1'b1);

        // R2/R3/R4: fill all eight slots then pack
        cur_tag = "R2";
        for (int s = 0; s < 8; s++) send(rand_word(), 10'(s * 8), 1'b0);
        cur_tag = "R4";
        send(rand_word(), 10'd0, 1'b1);

        // R5: second overhead right away reads zero
        cur_tag = "R5";
        send(rand_word(), 10'd0, 1'b1);

        // R3: hand-computed vector, burst0 = 1 in slot 0 -> 0x83
        cur_tag = "R3";
        w = '0; w[0] = 1'b1;
        send(w, 10'd0, 1'b0);
        send(rand_word(), 10'd0, 1'b1);
        hand = '0; hand[7:0] = 8'h83;
        check("R3", exp_q.size() == 0 || exp_q[exp_q.size()-1].d == hand,
              exp_q.size() == 0 ? hand : exp_q[exp_q.size()-1].d, hand);

        // R6/R10: slot 2 written twice, with unrelated column bits
        cur_tag = "R6";
        send(rand_word(), 10'h011, 1'b0);
        send(rand_word(), 10'h3D1, 1'b0);
        cur_tag = "R10";
        send(rand_word(), 10'h2C6, 1'b0);  // slot 0
        send(rand_word(), 10'd0, 1'b1);

        // R7/R9: fill output and skid under stall, then overhead waits
        repeat (4) @(posedge clk);
        ready_mode = 1;
        @(negedge clk);
        cur_tag = "R9";
        send(rand_word(), 10'd40, 1'b0);
        send(rand_word(), 10'd48, 1'b0);
        @(negedge clk);
        #1;
        check("R7", in_ready == 1'b0, {511'b0, in_ready}, '0);
        fork
            send(rand_word(), 10'd0, 1'b1);
        join_none
        repeat (5) @(posedge clk);
        ready_mode = 0;
        wait fork;

        // random phase
        ready_mode = 2;
        cur_tag = "R7";
        for (int i = 0; i < 300; i++) begin
            if (($urandom % 9) == 0) send(rand_word(), 10'($urandom), 1'b1);
            else                     send(rand_word(), 10'($urandom), 1'b0);
        end
        cur_tag = "R9";
        send(rand_word(), 10'd0, 1'b1);

        ready_mode = 0;
        for (int t = 0; t < 50 && exp_q.size() != 0; t++) @(posedge clk);
        repeat (2) @(negedge clk);
        check("R7", exp_q.size() == 0, 512'(exp_q.size()), '0);
        finish_run();
    end

endmodule